// File: doc/BRIEF.md
# Compare and Branch Resolution Unit

This unit resolves relational tests for a small 8-bit core. A compare subtracts the second operand from the first and throws the difference away. The resulting condition flags are kept in the low five bits of an 8-bit status register. A later conditional branch reads those stored flags and decides whether it is taken. The relational operator lives in the branch code, not in the compare, so signed and unsigned tests read different flags.

The unit also produces the next program counter in program words. A taken branch goes to the current PC plus one plus a short signed offset. An unconditional relative jump uses the same formula with a wider offset. Any other case goes to the current PC plus one. Greater-than and less-or-equal tests have no codes of their own: software swaps the compare operands to get them.

Top module: `cbr_unit`

## Requirements
- R1: On a rising clock edge with cmp_i high, sreg_o[4:0] loads the flags of opa_i minus opb_i. The bit positions are carry C=bit0, zero Z=bit1, negative N=bit2, overflow V=bit3 and sign S=bit4. The difference itself is never output.
- R2: C is set when opa_i is below opb_i as unsigned values (a borrow occurs). Z is set when the 8-bit difference is zero.
- R3: N equals bit 7 of the difference. V is set when the subtraction overflows as two's complement. S equals N XOR V.
- R4: Reset (rst_ni low) clears sreg_o to zero. sreg_o keeps its value on edges where cmp_i is low. sreg_o[7:5] always reads zero.
- R5: br_op_i code 0 is never taken. Code 1 (equal) is taken when Z is set. Code 2 (not equal) is taken when Z is clear.
- R6: Code 3 (unsigned same or higher) is taken when C is clear. Code 4 (unsigned lower) is taken when C is set.
- R7: Code 5 (signed greater or equal) is taken when S is clear. Code 6 (signed less than) is taken when S is set.
- R8: For a taken code from 1 to 6, next_pc_o = pc_i + 1 + the sign-extended off_i[6:0]. off_i[11:7] has no effect on this target.
- R9: Code 7 is a relative jump. It is always taken, with next_pc_o = pc_i + 1 + the sign-extended off_i[11:0].
- R10: When not taken, next_pc_o = pc_i + 1. All target arithmetic wraps modulo 2^16.
- R11: taken_o and next_pc_o are combinational and use only the stored flags. A compare strobed in the same cycle affects a branch only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Compare strobe |
| opa_i | input | 8 | First compare operand (minuend) |
| opb_i | input | 8 | Second compare operand (subtrahend) |
| br_op_i | input | 3 | Branch code: 0 none, 1 eq, 2 ne, 3 same/higher, 4 lower, 5 ge, 6 lt, 7 jump |
| off_i | input | 12 | Signed word offset; a conditional branch uses bits 6:0 |
| pc_i | input | 16 | Address of the branch word |
| sreg_o | output | 8 | Status register |
| taken_o | output | 1 | Branch or jump taken |
| next_pc_o | output | 16 | Next program counter |

## Verification
The bench uses the default parameters: 8-bit data, a 16-bit PC, a 7-bit branch offset and a 12-bit jump offset. With 8-bit data the compare operands can sit right on the sign and carry boundaries (0x7F, 0x80, 0xFF, equal values), so every flag combination that matters to the six conditions is reached. With a 16-bit PC and both offset widths at their extremes, both ends of the branch range, both ends of the jump range and the wrap past 0xFFFF are all reachable.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_EQ   = 3'd1,
    BR_NE   = 3'd2,
    BR_SH   = 3'd3,
    BR_LO   = 3'd4,
    BR_GE   = 3'd5,
    BR_LT   = 3'd6,
    BR_JMP  = 3'd7
  } br_op_e;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_V = 3;
  localparam int unsigned FLAG_S = 4;
  localparam int unsigned NFLAGS = 5;
endpackage

// File: rtl/cbr_flags.sv
module cbr_flags #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]              a_i,
  input  logic [DW-1:0]              b_i,
  output logic [cbr_pkg::NFLAGS-1:0] flags_o
);
  import cbr_pkg::*;

  logic [DW:0] diff;
  logic        c, z, n, v;

  always_comb begin
    diff = {1'b0, a_i} - {1'b0, b_i};
    c    = diff[DW];
    z    = (diff[DW-1:0] == '0);
    n    = diff[DW-1];
    v    = (a_i[DW-1] ^ b_i[DW-1]) & (a_i[DW-1] ^ diff[DW-1]);
    flags_o         = '0;
    flags_o[FLAG_C] = c;
    flags_o[FLAG_Z] = z;
    flags_o[FLAG_N] = n;
    flags_o[FLAG_V] = v;
    flags_o[FLAG_S] = n ^ v;
  end
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond (
  input  logic [2:0]                 op_i,
  input  logic [cbr_pkg::NFLAGS-1:0] flags_i,
  output logic                       taken_o,
  output logic                       is_jmp_o
);
  import cbr_pkg::*;

  always_comb begin
    is_jmp_o = 1'b0;
    unique case (br_op_e'(op_i))
      BR_NONE: taken_o = 1'b0;
      BR_EQ:   taken_o =  flags_i[FLAG_Z];
      BR_NE:   taken_o = ~flags_i[FLAG_Z];
      BR_SH:   taken_o = ~flags_i[FLAG_C];
      BR_LO:   taken_o =  flags_i[FLAG_C];
      BR_GE:   taken_o = ~flags_i[FLAG_S];
      BR_LT:   taken_o =  flags_i[FLAG_S];
      BR_JMP:  begin taken_o = 1'b1; is_jmp_o = 1'b1; end
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
  parameter int unsigned PCW    = 16,
  parameter int unsigned BOFF_W = 7,
  parameter int unsigned JOFF_W = 12
) (
  input  logic [PCW-1:0]    pc_i,
  input  logic [JOFF_W-1:0] off_i,
  input  logic              taken_i,
  input  logic              is_jmp_i,
  output logic [PCW-1:0]    next_pc_o
);
  localparam int unsigned BEXT = PCW - BOFF_W;
  localparam int unsigned JEXT = PCW - JOFF_W;

  logic [PCW-1:0] pc_inc, boff_x, joff_x;

  always_comb begin
    pc_inc    = pc_i + PCW'(1);
    boff_x    = {{BEXT{off_i[BOFF_W-1]}}, off_i[BOFF_W-1:0]};
    joff_x    = {{JEXT{off_i[JOFF_W-1]}}, off_i};
    next_pc_o = !taken_i ? pc_inc : (pc_inc + (is_jmp_i ? joff_x : boff_x));
  end
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit #(
  parameter int unsigned DW     = 8,
  parameter int unsigned SRW    = 8,
  parameter int unsigned PCW    = 16,
  parameter int unsigned BOFF_W = 7,
  parameter int unsigned JOFF_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_i,
  input  logic [DW-1:0]     opa_i,
  input  logic [DW-1:0]     opb_i,
  input  logic [2:0]        br_op_i,
  input  logic [JOFF_W-1:0] off_i,
  input  logic [PCW-1:0]    pc_i,
  output logic [SRW-1:0]    sreg_o,
  output logic              taken_o,
  output logic [PCW-1:0]    next_pc_o
);
  import cbr_pkg::*;

  logic [NFLAGS-1:0] flags_d, flags_q;
  logic              is_jmp;

  cbr_flags #(.DW(DW)) u_flags (
    .a_i(opa_i), .b_i(opb_i), .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (cmp_i) flags_q <= flags_d;
  end

  assign sreg_o = {{(SRW-NFLAGS){1'b0}}, flags_q};

  cbr_cond u_cond (
    .op_i(br_op_i), .flags_i(flags_q), .taken_o(taken_o), .is_jmp_o(is_jmp)
  );

  cbr_target #(.PCW(PCW), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W)) u_target (
    .pc_i(pc_i), .off_i(off_i), .taken_i(taken_o), .is_jmp_i(is_jmp),
    .next_pc_o(next_pc_o)
  );

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_i |=> $stable(sreg_o)); // R4
  AST_EQUAL_SETS_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && opa_i == opb_i) |=> (sreg_o[FLAG_Z] && !sreg_o[FLAG_C])); // R2
  AST_BORROW_SETS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && opa_i < opb_i) |=> sreg_o[FLAG_C]); // R2
  AST_NONE_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_op_i == BR_NONE) |-> !taken_o); // R5
  AST_JMP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_op_i == BR_JMP) |-> taken_o); // R9
  AST_FALL_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> (next_pc_o == pc_i + PCW'(1))); // R10
endmodule

// File: tb/tb_cbr_unit.sv
`timescale 1ns/1ps
module tb_cbr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp = 1'b0;
  logic [7:0]  opa = '0, opb = '0;
  logic [2:0]  op = '0;
  logic [11:0] off = '0;
  logic [15:0] pc = '0;
  logic [7:0]  sreg;
  logic        taken;
  logic [15:0] npc;

  int checks = 0;
  int errors = 0;

  cbr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .opa_i(opa), .opb_i(opb),
    .br_op_i(op), .off_i(off), .pc_i(pc), .sreg_o(sreg), .taken_o(taken),
    .next_pc_o(npc)
  );

  always #4 clk = ~clk;

  // {opa, opb, expected flags S V N Z C}
  localparam logic [20:0] VEC [8] = '{
    {8'h05, 8'h05, 5'b00010},
    {8'h03, 8'h05, 5'b10101},
    {8'h05, 8'h03, 5'b00000},
    {8'h80, 8'h01, 5'b11000},
    {8'h7F, 8'hFF, 5'b01101},
    {8'hFF, 8'h01, 5'b10100},
    {8'h00, 8'h80, 5'b01101},
    {8'h80, 8'h80, 5'b00010}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmp(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); opa = a; opb = b; cmp = 1'b1;
    @(negedge clk); cmp = 1'b0;
  endtask

  function automatic logic ref_taken(input logic [2:0] o, input logic [4:0] f);
    case (o)
      3'd1: return f[1];
      3'd2: return !f[1];
      3'd3: return !f[0];
      3'd4: return f[0];
      3'd5: return !f[4];
      3'd6: return f[4];
      3'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic br(input logic [2:0] o, input logic [11:0] of, input logic [15:0] p);
    op = o; off = of; pc = p; #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R4 reset sreg", sreg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 sreg after reset", sreg, 0);

    for (int i = 0; i < 8; i++) begin
      do_cmp(VEC[i][20:13], VEC[i][12:5]);
      chk($sformatf("R1 R2 R3 flags vec %0d", i), sreg, {3'b000, VEC[i][4:0]});
      for (int o = 0; o < 7; o++) begin
        logic t;
        t = ref_taken(3'(o), VEC[i][4:0]);
        br(3'(o), 12'h003, 16'h1000);
        chk($sformatf("R5 R6 R7 taken vec %0d op %0d", i, o), taken, t);
        chk($sformatf("R8 R10 npc vec %0d op %0d", i, o), npc, t ? 16'h1004 : 16'h1001);
      end
    end

    // R4 hold while strobe low
    @(negedge clk); opa = 8'h01; opb = 8'h02;
    repeat (2) @(negedge clk);
    chk("R4 hold without strobe", sreg, 8'h02);

    // R11 same-cycle compare does not affect branch before edge
    @(negedge clk); opa = 8'h01; opb = 8'h02; cmp = 1'b1; br(3'd1, 12'h000, 16'h0040);
    chk("R11 old flags used", taken, 1);
    @(negedge clk); cmp = 1'b0; #1;
    chk("R11 new flags after edge", taken, 0);

    // R8 offset extremes, upper bits ignored; flags now C set
    br(3'd4, 12'h040, 16'h1000);
    chk("R8 min branch offset", npc, 16'h0FC1);
    br(3'd4, 12'h03F, 16'h1000);
    chk("R8 max branch offset", npc, 16'h1040);
    br(3'd4, 12'hF81, 16'h1000);
    chk("R8 upper offset bits ignored", npc, 16'h1002);

    // R9 jump extremes
    br(3'd7, 12'h800, 16'h1000);
    chk("R9 jump taken", taken, 1);
    chk("R9 min jump offset", npc, 16'h0801);
    br(3'd7, 12'h7FF, 16'h1000);
    chk("R9 max jump offset", npc, 16'h1800);

    // R10 wrap
    br(3'd0, 12'h7FF, 16'hFFFF);
    chk("R10 not taken wrap", npc, 16'h0000);
    br(3'd7, 12'h002, 16'hFFFE);
    chk("R10 jump wrap", npc, 16'h0001);
    br(3'd7, 12'hFFD, 16'h0001);
    chk("R10 backward wrap", npc, 16'hFFFF);
    chk("R4 upper sreg bits zero", {29'd0, sreg[7:5]}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule